// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block runs one CAS-before-RAS refresh cycle on a fast-page-mode DRAM for every refresh request it accepts. It drives the active-low row and column strobes (`ras_n_o`, `cas_n_o`). It runs on a timing clock at twice the memory clock, so one timing-clock cycle is half a memory clock. Every strobe interval is a whole number of these half-clock units.

Two 2-bit fields shape the waveform:
- `pre_sel_i` selects the precharge length.
- `pw_sel_i` selects the pulse width.

Both fields are captured when a request is accepted and held until the cycle ends. The value 3 is reserved in each field and is treated as 2.

A request is accepted when `req_i` is high while the block is idle. `ack_o` marks the cycle of acceptance, `busy_o` covers the whole sequence, and `done_o` pulses once at the end.

The controller has five states:
- IDLE → CAS_PRE when a request is seen.
- CAS_PRE → CAS_SETUP when the column-precharge count expires.
- CAS_SETUP → RAS_LOW after one unit.
- RAS_LOW → FINISH when the row-low count expires.
- FINISH → IDLE unconditionally.

Both strobes are high in IDLE, CAS_PRE and FINISH. In CAS_SETUP only the column strobe is low. In RAS_LOW both strobes are low.

Top module: `cbr_refresh_seq`

## Requirements
- R1: During and after reset, and in idle, `ras_n_o` and `cas_n_o` are 1 and `busy_o`, `done_o` are 0. Reset is asynchronous and returns the strobes high at once, even in mid-sequence.
- R2: `ack_o` is 1 in any cycle where `req_i` is 1 and the block is idle. `busy_o` is 1 from the next cycle until the sequence ends.
- R3: After acceptance both strobes stay high for 4 cycles when `pre_sel_i` was 0, and for 2 cycles when it was 1 or 2.
- R4: `cas_n_o` falls exactly 1 cycle before `ras_n_o` falls, and `ras_n_o` never is 0 while `cas_n_o` is 1.
- R5: The number of cycles with `ras_n_o` low is selected by the pair (`pw_sel_i`, `pre_sel_i`):

  | `pw_sel_i` | `pre_sel_i` = 0 | `pre_sel_i` = 1 or 2 |
  |---|---|---|
  | 0 | 5 | 7 |
  | 1 | 3 | 5 |
  | 2 | 1 | 3 |

- R6: `cas_n_o` stays low after `ras_n_o` falls for the same count as R5, so both strobes rise on the same clock edge.
- R7: A field value of 3 gives the same timing as the value 2, in either field.
- R8: Changes to `pre_sel_i` and `pw_sel_i` while `busy_o` is 1 do not affect the running sequence.
- R9: While `busy_o` is 1, `req_i` is ignored: `ack_o` stays 0 and the sequence timing is unchanged.
- R10: In the cycle after both strobes return high, `done_o` is 1 for exactly one cycle with the strobes high. In the following cycle `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Refresh request |
| ack_o | output | 1 | Request accepted in this cycle |
| busy_o | output | 1 | Refresh sequence in progress |
| done_o | output | 1 | One-cycle end-of-refresh pulse |
| pre_sel_i | input | 2 | Precharge length select (3 acts as 2) |
| pw_sel_i | input | 2 | Row pulse width select (3 acts as 2) |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |

## Verification
The bench builds the block with its default parameters. With these, the precharge lengths are 4 and 2 units and the row-low lengths range from 1 to 7 units, so the 4-bit interval counter covers every interval the table can ask for. All ten field pairs in the stimulus table are reachable, including the reserved value in both fields. Every interval can be measured cycle by cycle at the ports. The shortest row-low case of one unit exercises a counter that expires immediately after load.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CAS_PRE   = 3'd1,
        ST_CAS_SETUP = 3'd2,
        ST_RAS_LOW   = 3'd3,
        ST_FINISH    = 3'd4
    } cbr_state_e;

    // Reserved field value 3 folds onto 2.
    function automatic logic [1:0] fold_sel(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/cbr_timing_sel.sv
module cbr_timing_sel #(
    parameter int CNT_W     = 4,
    parameter int PRE_LONG  = 4,
    parameter int PRE_SHORT = 2,
    parameter int RAS_PW0   = 5,
    parameter int RAS_PW1   = 3,
    parameter int RAS_PW2   = 1,
    parameter int RAS_EXT   = 2
) (
    input  logic [1:0]       pre_sel_i,
    input  logic [1:0]       pw_sel_i,
    output logic [CNT_W-1:0] cas_pre_len_o,
    output logic [CNT_W-1:0] ras_low_len_o
);
    import cbr_refresh_pkg::*;

    localparam logic [CNT_W-1:0] L_PRE_LONG  = CNT_W'(PRE_LONG);
    localparam logic [CNT_W-1:0] L_PRE_SHORT = CNT_W'(PRE_SHORT);
    localparam logic [CNT_W-1:0] L_EXT       = CNT_W'(RAS_EXT);

    logic [1:0]       pre_f;
    logic [1:0]       pw_f;
    logic [CNT_W-1:0] ras_base;

    always_comb begin
        pre_f = fold_sel(pre_sel_i);
        pw_f  = fold_sel(pw_sel_i);

        unique case (pw_f)
            2'd0:    ras_base = CNT_W'(RAS_PW0);
            2'd1:    ras_base = CNT_W'(RAS_PW1);
            default: ras_base = CNT_W'(RAS_PW2);
        endcase

        cas_pre_len_o = (pre_f == 2'd0) ? L_PRE_LONG : L_PRE_SHORT;
        ras_low_len_o = (pre_f == 2'd0) ? ras_base : ras_base + L_EXT;
    end

endmodule

// File: rtl/cbr_interval_counter.sv
module cbr_interval_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
    parameter int CNT_W     = 4,
    parameter int PRE_LONG  = 4,
    parameter int PRE_SHORT = 2,
    parameter int SETUP_LEN = 1,
    parameter int RAS_PW0   = 5,
    parameter int RAS_PW1   = 3,
    parameter int RAS_PW2   = 1,
    parameter int RAS_EXT   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    output logic       ack_o,
    output logic       busy_o,
    output logic       done_o,
    input  logic [1:0] pre_sel_i,
    input  logic [1:0] pw_sel_i,
    output logic       ras_n_o,
    output logic       cas_n_o
);
    import cbr_refresh_pkg::*;

    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] SETUP_CNT = CNT_W'(SETUP_LEN - 1);

    cbr_state_e       state_q, state_d;
    logic [1:0]       pre_q, pw_q;
    logic [CNT_W-1:0] cas_pre_len, ras_low_len;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_expired;
    logic             accept;

    // Lengths come from the captured fields, so mid-cycle changes are invisible.
    cbr_timing_sel #(
        .CNT_W    (CNT_W),
        .PRE_LONG (PRE_LONG),
        .PRE_SHORT(PRE_SHORT),
        .RAS_PW0  (RAS_PW0),
        .RAS_PW1  (RAS_PW1),
        .RAS_PW2  (RAS_PW2),
        .RAS_EXT  (RAS_EXT)
    ) u_sel (
        .pre_sel_i    (pre_q),
        .pw_sel_i     (pw_q),
        .cas_pre_len_o(cas_pre_len),
        .ras_low_len_o(ras_low_len)
    );

    cbr_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cnt_load),
        .load_val_i(cnt_val),
        .expired_o (cnt_expired)
    );

    assign accept = (state_q == ST_IDLE) && req_i;

    // The pre-phase count must use the incoming fields, since pre_q updates on the same edge.
    logic [CNT_W-1:0] pre_len_now;
    logic [CNT_W-1:0] unused_ras_now;

    cbr_timing_sel #(
        .CNT_W    (CNT_W),
        .PRE_LONG (PRE_LONG),
        .PRE_SHORT(PRE_SHORT),
        .RAS_PW0  (RAS_PW0),
        .RAS_PW1  (RAS_PW1),
        .RAS_PW2  (RAS_PW2),
        .RAS_EXT  (RAS_EXT)
    ) u_sel_in (
        .pre_sel_i    (pre_sel_i),
        .pw_sel_i     (pw_sel_i),
        .cas_pre_len_o(pre_len_now),
        .ras_low_len_o(unused_ras_now)
    );

    // State register and captured configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pre_q   <= 2'd0;
            pw_q    <= 2'd0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pre_q <= pre_sel_i;
                pw_q  <= pw_sel_i;
            end
        end
    end

    // Next-state logic and interval loads.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d  = ST_CAS_PRE;
                    cnt_load = 1'b1;
                    cnt_val  = pre_len_now - ONE;
                end
            end
            ST_CAS_PRE: begin
                if (cnt_expired) begin
                    state_d  = ST_CAS_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = SETUP_CNT;
                end
            end
            ST_CAS_SETUP: begin
                if (cnt_expired) begin
                    state_d  = ST_RAS_LOW;
                    cnt_load = 1'b1;
                    cnt_val  = ras_low_len - ONE;
                end
            end
            ST_RAS_LOW: begin
                if (cnt_expired) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        done_o  = 1'b0;
        busy_o  = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_CAS_PRE:   ;
            ST_CAS_SETUP: cas_n_o = 1'b0;
            ST_RAS_LOW: begin
                cas_n_o = 1'b0;
                ras_n_o = 1'b0;
            end
            ST_FINISH:    done_o = 1'b1;
            default:      busy_o = 1'b0;
        endcase
        ack_o = accept;
    end

    // Row strobe low only under a low column strobe (R4, R6).
    p_ras_under_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);

    // Column strobe falls while the row strobe is still high (R4).
    p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> ras_n_o);

    // Both strobes release together (R6).
    p_joint_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> $rose(cas_n_o));

    // Done lasts one cycle and is followed by idle (R10).
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // Idle keeps both strobes high (R1).
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ras_n_o && cas_n_o && !done_o));

    // No acknowledge while busy (R9).
    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ack_o);

    // Captured fields hold for the whole sequence (R8).
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(pre_q) && $stable(pw_q)));

    // An acknowledge starts the sequence on the next cycle (R2).
    p_ack_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> busy_o);

endmodule

// File: tb/cbr_refresh_seq_tb.sv
module cbr_refresh_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [1:0] pre_sel_i = 2'd0;
    logic [1:0] pw_sel_i = 2'd0;
    logic       ack_o, busy_o, done_o, ras_n_o, cas_n_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cbr_refresh_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .ack_o    (ack_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .pre_sel_i(pre_sel_i),
        .pw_sel_i (pw_sel_i),
        .ras_n_o  (ras_n_o),
        .cas_n_o  (cas_n_o)
    );

    // {pw, pre, expected precharge cycles, expected row-low cycles}
    // Rows 0-6 cover the six-entry table (R5); rows 7-9 use the reserved value 3 (R7).
    localparam int NVEC = 10;
    localparam logic [11:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 4'd4, 4'd5},
        {2'd0, 2'd1, 4'd2, 4'd7},
        {2'd0, 2'd2, 4'd2, 4'd7},
        {2'd1, 2'd0, 4'd4, 4'd3},
        {2'd1, 2'd1, 4'd2, 4'd5},
        {2'd2, 2'd0, 4'd4, 4'd1},
        {2'd2, 2'd2, 4'd2, 4'd3},
        {2'd3, 2'd3, 4'd2, 4'd3},
        {2'd3, 2'd0, 4'd4, 4'd1},
        {2'd0, 2'd3, 4'd2, 4'd7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one refresh and measure every interval at the ports.
    task automatic run_seq(input logic [1:0] pw, input logic [1:0] pre,
                           input int exp_p, input int exp_n,
                           input bit alter, input bit poke, input string tag);
        int cp = 0, su = 0, rl = 0, dn = 0, bad = 0, ackb = 0, guard = 0;
        int phase = 0;
        bit order_ok = 1'b1;
        @(negedge clk);
        pw_sel_i  = pw;
        pre_sel_i = pre;
        req_i     = 1'b1;
        #1;
        chk(ack_o == 1'b1, {"R2 ack ", tag}, int'(ack_o), 1);
        @(negedge clk);
        req_i = 1'b0;
        if (alter) begin
            pw_sel_i  = ~pw;
            pre_sel_i = ~pre;
        end
        chk(busy_o == 1'b1, {"R2 busy ", tag}, int'(busy_o), 1);
        while (busy_o && guard < 40) begin
            int ph;
            if (done_o) begin dn++; ph = 3; end
            else if (ras_n_o && cas_n_o) begin cp++; ph = 0; end
            else if (ras_n_o && !cas_n_o) begin su++; ph = 1; end
            else if (!ras_n_o && !cas_n_o) begin rl++; ph = 2; end
            else begin bad++; ph = phase; end
            if (ph < phase) order_ok = 1'b0;
            phase = ph;
            if (ack_o) ackb++;
            if (done_o && !(ras_n_o && cas_n_o)) bad++;
            if (poke) req_i = !ras_n_o;
            @(negedge clk);
            guard++;
        end
        req_i = 1'b0;
        chk(cp == exp_p, {"R3 precharge ", tag}, cp, exp_p);
        chk(su == 1, {"R4 setup ", tag}, su, 1);
        chk(rl == exp_n, {"R5 ras low ", tag}, rl, exp_n);
        chk(bad == 0 && order_ok, {"R6 cas hold/order ", tag}, bad, 0);
        chk(dn == 1, {"R10 done count ", tag}, dn, 1);
        chk(!busy_o && !done_o && ras_n_o && cas_n_o, {"R10 idle after ", tag},
            int'(busy_o), 0);
        if (poke) chk(ackb == 0, {"R9 ack while busy ", tag}, ackb, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        #5;
        chk(ras_n_o && cas_n_o && !busy_o && !done_o, "R1 in reset",
            int'(ras_n_o), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n_o && cas_n_o && !busy_o && !done_o, "R1 after reset",
            int'(busy_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_seq(VEC[i][11:10], VEC[i][9:8], int'(VEC[i][7:4]),
                    int'(VEC[i][3:0]), 1'b0, 1'b0,
                    (i >= 7) ? "R7 table" : "R5 table");
        end

        // R8: fields flipped right after acceptance.
        run_seq(2'd0, 2'd0, 4, 5, 1'b1, 1'b0, "R8 alter");
        run_seq(2'd2, 2'd1, 2, 3, 1'b1, 1'b0, "R8 alter2");

        // R9: request raised while the row strobe is low.
        run_seq(2'd1, 2'd0, 4, 3, 1'b0, 1'b1, "R9 poke");
        repeat (2) @(negedge clk);
        chk(!busy_o, "R9 no restart", int'(busy_o), 0);

        // R1: asynchronous reset in the middle of the row-low phase.
        @(negedge clk);
        pw_sel_i  = 2'd0;
        pre_sel_i = 2'd1;
        req_i     = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(!ras_n_o, "R1 mid-seq ras low before reset", int'(ras_n_o), 0);
        rst_n = 1'b0;
        #1;
        chk(ras_n_o && cas_n_o && !busy_o, "R1 mid-seq reset", int'(ras_n_o), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && ras_n_o && cas_n_o, "R1 idle after reset", int'(busy_o), 0);

        // Back-to-back requests after reset recovery still time correctly.
        run_seq(2'd2, 2'd0, 4, 1, 1'b0, 1'b0, "R5 post-reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule